// File: doc/BRIEF.md
# Patchable Micro-Program Sequencer

This block steps a micro-instruction pointer through a fixed micro-code ROM and can divert that flow into a small writable patch RAM. Each cycle the pointer normally takes the next or branch address that the current micro-word supplies. A bank of breakpoint pairs watches the pointer. Each pair holds an arm bit, a trigger address and a target address. When the pointer equals an armed trigger, the pointer is loaded with the paired target on the next cycle, whatever next address was supplied. The micro-word fetched in the trapping cycle is flagged so that downstream logic can discard it.

Patch RAM words sit in an address window directly above the ROM window. A patch routine therefore returns to the original flow by branching to any ROM address. An update agent fills the patch RAM and then arms the pairs through a load port. The load port takes effect only while an update-enable input is high. A soft restart returns the pointer to the reset entry without disturbing the loaded patches. A pair armed on that entry therefore lets the ROM reset routine be skipped.

Top module: `ucode_patch_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, the pointer is 0 and every pair is unarmed. Every patch RAM word reads as 0x0000.
- R2: In a cycle with no trap and no restart, the pointer on the next clock edge equals `next_addr_i`.
- R3: For pointer values 0 to 255 (ROM window), `uword_o` equals 16'hC3A0 XOR the zero-extended pointer.
- R4: For pointer values 256 to 315 (patch window), `uword_o` is the patch RAM word at index pointer−256. For pointer values 316 and above, `uword_o` is 0x0000.
- R5: If the pointer equals the trigger of an armed pair, `trap_o` is high in that cycle. On the next edge the pointer takes that pair's target, so the redirection costs exactly one cycle.
- R6: A pair whose arm bit is 0 never causes a trap.
- R7: When several armed pairs trigger on the same pointer, the target of the lowest-numbered pair is taken.
- R8: A load with `ld_we_i` high changes nothing unless `upd_en_i` is high. `ld_pair_i`=0 writes the patch RAM word at relative index `ld_idx_i`; indices of 60 and above are dropped. `ld_pair_i`=1 writes pair `ld_idx_i` (0 to 3) with `ld_arm_i`, `ld_match_i` and `ld_dest_i`.
- R9: `restart_i` loads the pointer with 0 on the next edge and takes priority over traps. Patches and pairs are kept, so a pair armed on address 0 diverts the restart past the ROM reset routine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all state |
| restart_i | input | 1 | Soft restart of the pointer to the reset entry |
| next_addr_i | input | 9 | Next or branch address from the current micro-word |
| upd_en_i | input | 1 | Update enable that gates all loads |
| ld_we_i | input | 1 | Load strobe |
| ld_pair_i | input | 1 | Load target: 0 selects patch RAM, 1 selects a breakpoint pair |
| ld_idx_i | input | 9 | Patch RAM relative index, or pair number |
| ld_word_i | input | 16 | Micro-word to store in patch RAM |
| ld_match_i | input | 9 | Trigger address for a pair |
| ld_dest_i | input | 9 | Target address for a pair |
| ld_arm_i | input | 1 | Arm bit for a pair |
| upc_o | output | 9 | Current micro-instruction pointer |
| uword_o | output | 16 | Fetched micro-word |
| trap_o | output | 1 | Breakpoint hit in this cycle; the micro-word is to be discarded |

## Verification
A corrupted pair shows up as a missing or spurious `trap_o` in the cycle the pointer reaches its trigger. It also shows up as a wrong `upc_o` one edge later. A bad patch RAM cell stays hidden until the pointer enters the patch window, and then it is visible directly on `uword_o`. The stimulus therefore visits every window boundary. It also makes overlapping and disarmed triggers reach the pointer, so that a priority or arm fault appears within one cycle.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;
    parameter int          UADDR_W     = 9;
    parameter int          WORD_W      = 16;
    parameter int          ROM_DEPTH   = 256;
    parameter int          PATCH_DEPTH = 60;
    parameter int          NPAIRS      = 4;
    parameter logic [15:0] ROM_KEY     = 16'hC3A0;
    parameter logic [8:0]  RESET_VEC   = 9'd0;
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom #(
    parameter int              UADDR_W = ucode_seq_pkg::UADDR_W,
    parameter int              WORD_W  = ucode_seq_pkg::WORD_W,
    parameter logic [WORD_W-1:0] KEY   = ucode_seq_pkg::ROM_KEY
) (
    input  logic [UADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0]  word_o
);
    // Fixed contents are generated from the address; no stored table.
    always_comb begin
        word_o = KEY ^ WORD_W'(addr_i);
    end
endmodule

// File: rtl/ucode_patch_ram.sv
module ucode_patch_ram #(
    parameter int UADDR_W = ucode_seq_pkg::UADDR_W,
    parameter int WORD_W  = ucode_seq_pkg::WORD_W,
    parameter int DEPTH   = ucode_seq_pkg::PATCH_DEPTH
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               upd_en_i,
    input  logic               we_i,
    input  logic [UADDR_W-1:0] wr_idx_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    input  logic [UADDR_W-1:0] rd_idx_i,
    output logic [WORD_W-1:0]  rd_word_o
);
    localparam int                 IDX_W   = $clog2(DEPTH);
    localparam logic [UADDR_W-1:0] DEPTH_A = UADDR_W'(DEPTH);

    logic [DEPTH-1:0][WORD_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (upd_en_i && we_i && (wr_idx_i < DEPTH_A)) begin
            mem_d[wr_idx_i[IDX_W-1:0]] = wr_data_i;
        end
        rd_word_o = (rd_idx_i < DEPTH_A) ? mem_q[rd_idx_i[IDX_W-1:0]] : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q <= '0;
        else         mem_q <= mem_d;
    end

    // Loads outside the update window leave the storage untouched.
    assert_ram_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_en_i |=> $stable(mem_q));
endmodule

// File: rtl/ucode_match_unit.sv
module ucode_match_unit #(
    parameter int UADDR_W = ucode_seq_pkg::UADDR_W,
    parameter int NPAIRS  = ucode_seq_pkg::NPAIRS
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               upd_en_i,
    input  logic               we_i,
    input  logic [UADDR_W-1:0] idx_i,
    input  logic               arm_i,
    input  logic [UADDR_W-1:0] match_i,
    input  logic [UADDR_W-1:0] dest_i,
    input  logic [UADDR_W-1:0] upc_i,
    output logic               hit_o,
    output logic [UADDR_W-1:0] dest_o
);
    localparam int                 IDX_W    = (NPAIRS > 1) ? $clog2(NPAIRS) : 1;
    localparam logic [UADDR_W-1:0] NPAIRS_A = UADDR_W'(NPAIRS);

    typedef struct packed {
        logic               arm;
        logic [UADDR_W-1:0] trig;
        logic [UADDR_W-1:0] dest;
    } bp_pair_t;

    bp_pair_t [NPAIRS-1:0] pair_d, pair_q;
    logic     [NPAIRS-1:0] eq;
    logic     [NPAIRS-1:0] armed;

    // One comparator per pair, all evaluated in parallel.
    for (genvar g = 0; g < NPAIRS; g++) begin : g_cmp
        assign armed[g] = pair_q[g].arm;
        assign eq[g]    = pair_q[g].arm && (pair_q[g].trig == upc_i);
    end

    always_comb begin
        pair_d = pair_q;
        if (upd_en_i && we_i && (idx_i < NPAIRS_A)) begin
            pair_d[idx_i[IDX_W-1:0]] = '{arm: arm_i, trig: match_i, dest: dest_i};
        end
        hit_o  = |eq;
        dest_o = '0;
        // Scan from the top so the lowest-numbered pair is applied last.
        for (int i = NPAIRS - 1; i >= 0; i--) begin
            if (eq[i]) dest_o = pair_q[i].dest;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pair_q <= '0;
        else         pair_q <= pair_d;
    end

    assert_pair_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_en_i |=> $stable(pair_q));

    assert_unarmed_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (|armed));

    assert_low_pair_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pair_q[0].arm && (pair_q[0].trig == upc_i)) |-> (dest_o == pair_q[0].dest));
endmodule

// File: rtl/ucode_patch_seq.sv
module ucode_patch_seq #(
    parameter int                 UADDR_W     = ucode_seq_pkg::UADDR_W,
    parameter int                 WORD_W      = ucode_seq_pkg::WORD_W,
    parameter int                 ROM_DEPTH   = ucode_seq_pkg::ROM_DEPTH,
    parameter int                 PATCH_DEPTH = ucode_seq_pkg::PATCH_DEPTH,
    parameter int                 NPAIRS      = ucode_seq_pkg::NPAIRS,
    parameter logic [WORD_W-1:0]  ROM_KEY     = ucode_seq_pkg::ROM_KEY,
    parameter logic [UADDR_W-1:0] RESET_VEC   = ucode_seq_pkg::RESET_VEC
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               restart_i,
    input  logic [UADDR_W-1:0] next_addr_i,
    input  logic               upd_en_i,
    input  logic               ld_we_i,
    input  logic               ld_pair_i,
    input  logic [UADDR_W-1:0] ld_idx_i,
    input  logic [WORD_W-1:0]  ld_word_i,
    input  logic [UADDR_W-1:0] ld_match_i,
    input  logic [UADDR_W-1:0] ld_dest_i,
    input  logic               ld_arm_i,
    output logic [UADDR_W-1:0] upc_o,
    output logic [WORD_W-1:0]  uword_o,
    output logic               trap_o
);
    localparam logic [UADDR_W-1:0] ROM_END_A   = UADDR_W'(ROM_DEPTH);
    localparam logic [UADDR_W-1:0] PATCH_END_A = UADDR_W'(ROM_DEPTH + PATCH_DEPTH);

    typedef struct packed {
        logic [UADDR_W-1:0] upc;
    } seq_state_t;

    seq_state_t         st_d, st_q;
    logic               hit;
    logic [UADDR_W-1:0] hit_dest;
    logic [WORD_W-1:0]  rom_word, ram_word;
    logic [UADDR_W-1:0] ram_rd_idx;
    logic               in_rom, in_patch;

    ucode_rom #(.UADDR_W(UADDR_W), .WORD_W(WORD_W), .KEY(ROM_KEY)) rom_i (
        .addr_i (st_q.upc),
        .word_o (rom_word)
    );

    ucode_patch_ram #(.UADDR_W(UADDR_W), .WORD_W(WORD_W), .DEPTH(PATCH_DEPTH)) ram_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .upd_en_i  (upd_en_i),
        .we_i      (ld_we_i && !ld_pair_i),
        .wr_idx_i  (ld_idx_i),
        .wr_data_i (ld_word_i),
        .rd_idx_i  (ram_rd_idx),
        .rd_word_o (ram_word)
    );

    ucode_match_unit #(.UADDR_W(UADDR_W), .NPAIRS(NPAIRS)) match_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .upd_en_i (upd_en_i),
        .we_i     (ld_we_i && ld_pair_i),
        .idx_i    (ld_idx_i),
        .arm_i    (ld_arm_i),
        .match_i  (ld_match_i),
        .dest_i   (ld_dest_i),
        .upc_i    (st_q.upc),
        .hit_o    (hit),
        .dest_o   (hit_dest)
    );

    always_comb begin
        // Address selection: restart, then breakpoint, then normal flow.
        st_d = st_q;
        if (restart_i)  st_d.upc = RESET_VEC;
        else if (hit)   st_d.upc = hit_dest;
        else            st_d.upc = next_addr_i;

        // Window decode selects which memory drives the micro-word.
        in_rom     = st_q.upc < ROM_END_A;
        in_patch   = !in_rom && (st_q.upc < PATCH_END_A);
        ram_rd_idx = st_q.upc - ROM_END_A;
        if (in_rom)        uword_o = rom_word;
        else if (in_patch) uword_o = ram_word;
        else               uword_o = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{upc: RESET_VEC};
        else         st_q <= st_d;
    end

    assign upc_o  = st_q.upc;
    assign trap_o = hit;

    assert_follow_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!trap_o && !restart_i) |=> (upc_o == $past(next_addr_i)));

    assert_trap_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_o && !restart_i) |=> (upc_o == $past(hit_dest)));

    assert_restart_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (upc_o == RESET_VEC));
endmodule

// File: tb/ucode_patch_seq_tb.sv
module ucode_patch_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 5000;

    logic        clk_i = 1'b0;
    logic        rst_ni, restart_i, upd_en_i, ld_we_i, ld_pair_i, ld_arm_i;
    logic [8:0]  next_addr_i, ld_idx_i, ld_match_i, ld_dest_i;
    logic [15:0] ld_word_i;
    logic [8:0]  upc_o;
    logic [15:0] uword_o;
    logic        trap_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    ucode_patch_seq dut_i (
        .clk_i, .rst_ni, .restart_i, .next_addr_i, .upd_en_i, .ld_we_i,
        .ld_pair_i, .ld_idx_i, .ld_word_i, .ld_match_i, .ld_dest_i,
        .ld_arm_i, .upc_o, .uword_o, .trap_o
    );

    // {pointer, expected micro-word} walked with no pair armed (R3, R4).
    localparam logic [24:0] VEC [8] = '{
        {9'h000, 16'hC3A0}, {9'h001, 16'hC3A1}, {9'h07F, 16'hC3DF},
        {9'h0FF, 16'hC35F}, {9'h100, 16'h0000}, {9'h13B, 16'h0000},
        {9'h13C, 16'h0000}, {9'h1FF, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go(input logic [8:0] a);
        next_addr_i = a;
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic ld_ram(input logic [8:0] idx, input logic [15:0] w);
        ld_pair_i = 1'b0; ld_idx_i = idx; ld_word_i = w; ld_we_i = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        ld_we_i = 1'b0;
    endtask

    task automatic ld_pair(input logic [8:0] idx, input logic arm,
                           input logic [8:0] trig, input logic [8:0] dest);
        ld_pair_i = 1'b1; ld_idx_i = idx; ld_arm_i = arm;
        ld_match_i = trig; ld_dest_i = dest; ld_we_i = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        ld_we_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout");
            finish_run();
        end
    end

    initial begin
        rst_ni = 1'b0; restart_i = 1'b0; upd_en_i = 1'b0; ld_we_i = 1'b0;
        ld_pair_i = 1'b0; ld_arm_i = 1'b0; next_addr_i = '0; ld_idx_i = '0;
        ld_match_i = '0; ld_dest_i = '0; ld_word_i = '0;
        repeat (2) @(negedge clk_i);
        check("R1 reset pointer", 32'(upc_o), 32'h0);
        check("R1 reset word", 32'(uword_o), 32'hC3A0);
        check("R1 reset no trap", 32'(trap_o), 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        for (int i = 0; i < 8; i++) begin
            go(VEC[i][24:16]);
            check("R2 pointer follows next address", 32'(upc_o), 32'(VEC[i][24:16]));
            check("R3/R4 window word", 32'(uword_o), 32'(VEC[i][15:0]));
            check("R6 no trap when unarmed", 32'(trap_o), 32'h0);
        end

        // R8: loads without the update enable are dropped.
        ld_ram(9'd0, 16'hBEEF);
        ld_pair(9'd0, 1'b1, 9'h005, 9'h100);
        go(9'h100);
        check("R8 gated RAM write ignored", 32'(uword_o), 32'h0);
        go(9'h005);
        check("R8 gated pair write ignored", 32'(trap_o), 32'h0);
        check("R3 ROM word at 0x005", 32'(uword_o), 32'hC3A5);

        upd_en_i = 1'b1;
        ld_ram(9'd0,  16'hBEEF);
        ld_ram(9'd1,  16'hCAFE);
        ld_ram(9'd59, 16'h1234);
        ld_ram(9'd60, 16'hFFFF);
        ld_pair(9'd0, 1'b0, 9'h020, 9'h13B);
        ld_pair(9'd1, 1'b1, 9'h020, 9'h100);
        ld_pair(9'd2, 1'b1, 9'h030, 9'h101);
        ld_pair(9'd3, 1'b1, 9'h030, 9'h13B);
        upd_en_i = 1'b0;

        go(9'h13B);
        check("R4 last patch word", 32'(uword_o), 32'h1234);
        go(9'h020);
        check("R5 trap raised at trigger", 32'(trap_o), 32'h1);
        check("R3 ROM word at trigger", 32'(uword_o), 32'hC380);
        go(9'h021);
        check("R5/R6 pointer takes armed target", 32'(upc_o), 32'h100);
        check("R4 first patch word", 32'(uword_o), 32'hBEEF);
        check("R5 trap cleared in patch", 32'(trap_o), 32'h0);
        go(9'h101);
        check("R4 second patch word", 32'(uword_o), 32'hCAFE);
        go(9'h021);
        check("R2 patch returns to ROM", 32'(upc_o), 32'h021);
        check("R3 ROM word after return", 32'(uword_o), 32'hC381);

        go(9'h030);
        check("R7 overlap trap", 32'(trap_o), 32'h1);
        go(9'h022);
        check("R7 lowest pair target", 32'(upc_o), 32'h101);

        upd_en_i = 1'b1;
        ld_pair(9'd1, 1'b0, 9'h020, 9'h100);
        upd_en_i = 1'b0;
        go(9'h020);
        check("R6 disarmed pair no trap", 32'(trap_o), 32'h0);
        go(9'h023);
        check("R6 disarmed pair flow kept", 32'(upc_o), 32'h023);

        upd_en_i = 1'b1;
        ld_pair(9'd3, 1'b1, 9'h000, 9'h00A);
        upd_en_i = 1'b0;
        restart_i = 1'b1;
        next_addr_i = 9'h040;
        @(posedge clk_i);
        @(negedge clk_i);
        restart_i = 1'b0;
        check("R9 restart entry", 32'(upc_o), 32'h0);
        check("R9 trap on reset entry", 32'(trap_o), 32'h1);
        @(posedge clk_i);
        @(negedge clk_i);
        check("R9 reset routine skipped", 32'(upc_o), 32'h00A);
        check("R9 word after skip", 32'(uword_o), 32'hC3AA);
        go(9'h041);
        check("R9 patch RAM kept after restart", 32'(upc_o), 32'h041);
        go(9'h100);
        check("R9 patch word kept after restart", 32'(uword_o), 32'hBEEF);

        done = 1'b1;
        finish_run();
    end
endmodule